// File: doc/BRIEF.md
# Fly-by DMA Request Slave

This block is the peripheral side of a fly-by DMA handshake for a device controller. When an endpoint buffer holds a packet of words bound for system memory, the packet's length is handed to the block over a valid/ready channel. The block then raises its request line and waits for the external DMA controller to grant the bus with an acknowledge. While the acknowledge and the read strobe are both active, the block drives the head word of the buffer onto a tri-stated 16-bit data bus. The external controller moves that word straight into memory: the data never passes through the DMA controller, and the block has no say in how long the cycle lasts.

Each completed strobe pops one word from the buffer and decrements the remaining count. The transfer mode is captured with the packet. In single-cycle mode the request is withdrawn after every word and raised again once the acknowledge has gone away. In burst mode the request is held until the last word has been taken. A one-cycle done pulse marks the end of each packet.

The acknowledge and strobe pins arrive asynchronously. They pass through two-flop synchronisers before they are used for any decision. The data bus enable is the exception: it is formed directly from the pins, so that the bus is released at once.

The packet channel follows valid/ready rules. `pkt_ready` is high only while no words of an earlier packet remain. A packet is taken on a clock edge where `pkt_valid` and `pkt_ready` are both high. `pkt_valid` raised while `pkt_ready` is low has no effect, and the offer may be withdrawn. The buffer side is a first-word-fall-through queue: `buf_data` is valid while `buf_valid` is high, and `buf_pop` consumes it.

Top module: `dma_req_slave`

## Requirements
- R1: `dreq` is high only while words of an accepted packet remain. After a packet with a nonzero length is accepted, `dreq` rises within three clock cycles.
- R2: `dbus_oe` is 1, and `dbus` carries `buf_data`, only while `dack` is 1, `rd_n` is 0 and a packet is active. Words appear on `dbus` in queue order.
- R3: When `dack` goes to 0 or `rd_n` goes to 1, `dbus_oe` falls without waiting for a clock edge. A strobe cut short by the loss of `dack` consumes no word.
- R4: A strobe completes when `rd_n` returns to 1 while `dack` is 1, both as seen after synchronisation. Each completed strobe gives exactly one `buf_pop` cycle and one decrement of the remaining count.
- R5: In single-cycle mode, `dreq` is 0 in the cycle after each completed strobe. If words remain, `dreq` returns to 1 on the clock after the synchronised `dack` is seen at 0.
- R6: In burst mode, `dreq` stays 1 across completed strobes while words remain. It drops after the last word.
- R7: `pkt_ready` is 1 exactly when no words remain. A packet's length is loaded only on a valid/ready handshake. An offer made while `pkt_ready` is 0 changes nothing.
- R8: `done` pulses for one cycle after the last word of a packet is popped. A packet of length 0 gives a `done` pulse without ever raising `dreq`.
- R9: A read strobe while `dack` is 0 is ignored: nothing is driven and nothing is popped.
- R10: `burst_mode` is sampled at the packet handshake (1 = burst, 0 = single-cycle). Changing it while a packet is active has no effect on that packet.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pkt_valid | input | 1 | Packet length offer valid |
| pkt_ready | output | 1 | Block can accept a packet |
| pkt_len | input | 10 | Number of words in the offered packet |
| burst_mode | input | 1 | 1 = burst, 0 = single-cycle, sampled at the handshake |
| buf_valid | input | 1 | Buffer head word is valid |
| buf_data | input | 16 | Buffer head word |
| buf_pop | output | 1 | Consume the head word |
| dreq | output | 1 | DMA request to the external controller |
| dack | input | 1 | DMA acknowledge, asynchronous, active high |
| rd_n | input | 1 | Read strobe, asynchronous, active low |
| dbus | inout | 16 | Tri-stated data bus |
| dbus_oe | output | 1 | High while the block drives `dbus` |
| done | output | 1 | One-cycle pulse at the end of a packet |

## Verification
The hardest case to reach is a strobe that is cut short: the acknowledge is removed while the read strobe is still active. In that case the bus must be released at once, and the word must stay in the queue for the next cycle. The bench produces this in the middle of a burst packet. It drops `dack` two cycles into a strobe, checks `dbus_oe` before the next edge, releases the strobe, and confirms that no pop occurred. The scoreboard then expects the same word again on the next full cycle. Two further cases need timed stimulus: a strobe pulsed without `dack`, and a mode flip made just after the packet handshake.

// File: rtl/dma_slave_pkg.sv
package dma_slave_pkg;

  // Request sequencer states.
  typedef enum logic [1:0] {
    RQ_IDLE = 2'd0,   // no words pending
    RQ_ASK  = 2'd1,   // request raised
    RQ_WAIT = 2'd2    // single-cycle: wait for acknowledge to clear
  } rq_state_e;

  localparam int unsigned DEF_DATA_W = 16;
  localparam int unsigned DEF_LEN_W  = 10;
  localparam int unsigned DEF_STAGES = 2;

endpackage

// File: rtl/dma_sync.sv
module dma_sync #(
  parameter int unsigned W      = 2,
  parameter int unsigned STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  logic [W-1:0] stage_q [STAGES];

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= d;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) stage_q[g] <= '0;
        else        stage_q[g] <= stage_q[g-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];

endmodule

// File: rtl/dma_strobe_detect.sv
module dma_strobe_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic strb_s,   // synchronised strobe, active high
  input  logic ack_s,    // synchronised acknowledge
  input  logic busy,
  output logic word_done
);

  logic strb_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) strb_q <= 1'b0;
    else        strb_q <= strb_s;
  end

  // A cycle completes when the strobe ends while the acknowledge still holds.
  assign word_done = strb_q & ~strb_s & ack_s & busy;

endmodule

// File: rtl/dma_pkt_tracker.sv
module dma_pkt_tracker #(
  parameter int unsigned LEN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pkt_valid,
  output logic             pkt_ready,
  input  logic [LEN_W-1:0] pkt_len,
  input  logic             burst_in,
  input  logic             word_done,
  output logic             busy,
  output logic             last_word,
  output logic             burst_q,
  output logic             done
);

  logic [LEN_W-1:0] remain_q;
  logic             accept;
  logic             finish;

  assign pkt_ready = (remain_q == '0);
  assign accept    = pkt_valid & pkt_ready;
  assign busy      = ~pkt_ready;
  assign last_word = (remain_q == LEN_W'(1));
  assign finish    = (word_done & last_word) | (accept & (pkt_len == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      remain_q <= '0;
      burst_q  <= 1'b0;
      done     <= 1'b0;
    end else begin
      done <= finish;
      if (accept) begin
        remain_q <= pkt_len;
        burst_q  <= burst_in;
      end else if (word_done) begin
        remain_q <= remain_q - LEN_W'(1);
      end
    end
  end

  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !word_done) |=> $stable(remain_q)); // R7
  AST_DONE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (remain_q == '0)); // R8
  AST_MODE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> $stable(burst_q)); // R10

endmodule

// File: rtl/dma_req_fsm.sv
module dma_req_fsm
  import dma_slave_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  input  logic last_word,
  input  logic burst_q,
  input  logic word_done,
  input  logic ack_s,
  output logic dreq
);

  rq_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      RQ_IDLE: if (busy) state_d = RQ_ASK;
      RQ_ASK: begin
        if (word_done) begin
          if (last_word)     state_d = RQ_IDLE;
          else if (!burst_q) state_d = RQ_WAIT;
        end
      end
      RQ_WAIT: begin
        if (!busy)       state_d = RQ_IDLE;
        else if (!ack_s) state_d = RQ_ASK;
      end
      default: state_d = RQ_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= RQ_IDLE;
    else        state_q <= state_d;
  end

  assign dreq = (state_q == RQ_ASK);

  AST_DREQ_NEEDS_WORDS: assert property (@(posedge clk) disable iff (!rst_n)
    dreq |-> busy); // R1
  AST_SINGLE_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !burst_q) |=> !dreq); // R5
  AST_BURST_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dreq && word_done && burst_q && !last_word) |=> dreq); // R6

endmodule

// File: rtl/dma_bus_drive.sv
module dma_bus_drive #(
  parameter int unsigned DATA_W = 16
) (
  input  logic              ack_pin,
  input  logic              rd_n_pin,
  input  logic              busy,
  input  logic [DATA_W-1:0] word,
  output logic              oe,
  inout  wire  [DATA_W-1:0] bus
);

  // Enable comes straight from the pins so release needs no clock edge.
  assign oe  = ack_pin & ~rd_n_pin & busy;
  assign bus = oe ? word : {DATA_W{1'bz}};

endmodule

// File: rtl/dma_req_slave.sv
module dma_req_slave
  import dma_slave_pkg::*;
#(
  parameter int unsigned DATA_W = DEF_DATA_W,
  parameter int unsigned LEN_W  = DEF_LEN_W,
  parameter int unsigned STAGES = DEF_STAGES
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              pkt_valid,
  output logic              pkt_ready,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              burst_mode,
  input  logic              buf_valid,
  input  logic [DATA_W-1:0] buf_data,
  output logic              buf_pop,
  output logic              dreq,
  input  logic              dack,
  input  logic              rd_n,
  inout  wire  [DATA_W-1:0] dbus,
  output logic              dbus_oe,
  output logic              done
);

  localparam int unsigned NSYNC = 2;

  logic [NSYNC-1:0] pin_raw, pin_s;
  logic ack_s, strb_s;
  logic word_done, busy, last_word, burst_q;

  assign pin_raw = {dack, ~rd_n};

  dma_sync #(.W(NSYNC), .STAGES(STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_raw), .q(pin_s)
  );
  assign ack_s  = pin_s[1];
  assign strb_s = pin_s[0];

  dma_strobe_detect u_strobe (
    .clk(clk), .rst_n(rst_n), .strb_s(strb_s), .ack_s(ack_s),
    .busy(busy), .word_done(word_done)
  );

  dma_pkt_tracker #(.LEN_W(LEN_W)) u_track (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_len(pkt_len), .burst_in(burst_mode), .word_done(word_done),
    .busy(busy), .last_word(last_word), .burst_q(burst_q), .done(done)
  );

  dma_req_fsm u_fsm (
    .clk(clk), .rst_n(rst_n), .busy(busy), .last_word(last_word),
    .burst_q(burst_q), .word_done(word_done), .ack_s(ack_s), .dreq(dreq)
  );

  dma_bus_drive #(.DATA_W(DATA_W)) u_bus (
    .ack_pin(dack), .rd_n_pin(rd_n), .busy(busy), .word(buf_data),
    .oe(dbus_oe), .bus(dbus)
  );

  assign buf_pop = word_done;

  AST_BUF_UNDERRUN: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |-> buf_valid); // R4
  AST_POP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    buf_pop |=> !buf_pop); // R4

endmodule

// File: tb/tb_dma_req_slave.sv
module tb_dma_req_slave;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        pkt_valid = 1'b0;
  logic        pkt_ready;
  logic [9:0]  pkt_len = '0;
  logic        burst_mode = 1'b0;
  logic        buf_valid;
  logic [15:0] buf_data;
  logic        buf_pop;
  logic        dreq;
  logic        dack = 1'b0;
  logic        rd_n = 1'b1;
  wire  [15:0] dbus;
  logic        dbus_oe;
  logic        done;

  dma_req_slave dut (
    .clk(clk), .rst_n(rst_n), .pkt_valid(pkt_valid), .pkt_ready(pkt_ready),
    .pkt_len(pkt_len), .burst_mode(burst_mode), .buf_valid(buf_valid),
    .buf_data(buf_data), .buf_pop(buf_pop), .dreq(dreq), .dack(dack),
    .rd_n(rd_n), .dbus(dbus), .dbus_oe(dbus_oe), .done(done)
  );

  int checks = 0;
  int failures = 0;
  int done_cnt = 0;
  bit finished = 1'b0;

  // Buffer model and scoreboard.
  logic [15:0] mem [64];
  int head = 0;
  int tail = 0;
  logic [15:0] exp_q [$];
  assign buf_valid = (head != tail);
  assign buf_data  = mem[head % 64];

  always @(posedge clk) if (buf_pop) head <= head + 1;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Monitor: compare words as they appear, retire them on pop.
  logic oe_prev = 1'b0;
  always @(negedge clk) begin
    if (dbus_oe && !oe_prev) begin
      if (exp_q.size() == 0) chk("R2 unexpected drive", 1, 0);
      else chk("R2 word order", int'(dbus), int'(exp_q[0]));
    end
    if (dbus_oe && (!dack || rd_n)) chk("R2 drive without dack and strobe", 1, 0);
    if (buf_pop && exp_q.size() > 0) void'(exp_q.pop_front());
    if (done) done_cnt++;
    oe_prev <= dbus_oe;
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic send_pkt(input int len, input bit burst, input int tagv);
    for (int i = 0; i < len; i++) begin
      logic [15:0] w;
      w = 16'(16'h1000 * tagv + 16'h0101 * i + 16'h0003);
      mem[tail % 64] = w;
      tail++;
      exp_q.push_back(w);
    end
    @(posedge clk); #1;
    pkt_len = 10'(len); burst_mode = burst; pkt_valid = 1'b1;
    do @(negedge clk); while (!pkt_ready);
    @(posedge clk); #1;
    pkt_valid = 1'b0;
  endtask

  task automatic wait_dreq();
    int t = 0;
    while (!dreq && t < 20) begin cyc(1); t++; end
    chk("R1 dreq raised", int'(dreq), 1);
  endtask

  task automatic strobe();
    rd_n = 1'b0;
    cyc(3);
    rd_n = 1'b1;
    cyc(5);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired actual=1 expected=0");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    int h0;
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    @(negedge clk);
    chk("R1 reset dreq", int'(dreq), 0);
    chk("R2 reset oe", int'(dbus_oe), 0);
    chk("R7 reset ready", int'(pkt_ready), 1);
    chk("R8 reset done", int'(done), 0);

    // Single-cycle packet of 3 words.
    send_pkt(3, 1'b0, 1);
    cyc(2); @(negedge clk);
    chk("R1 dreq within three cycles", int'(dreq), 1);
    chk("R7 ready low while busy", int'(pkt_ready), 0);
    // Offer while busy: must be ignored.
    pkt_len = 10'd5; pkt_valid = 1'b1; cyc(3); pkt_valid = 1'b0;
    // Strobe with no acknowledge.
    h0 = head;
    rd_n = 1'b0; cyc(2); @(negedge clk);
    chk("R9 no drive without dack", int'(dbus_oe), 0);
    cyc(1); rd_n = 1'b1; cyc(5); @(negedge clk);
    chk("R9 no pop without dack", head, h0);
    chk("R9 dreq kept", int'(dreq), 1);
    for (int i = 0; i < 3; i++) begin
      wait_dreq();
      dack = 1'b1; cyc(1);
      h0 = head;
      strobe(); @(negedge clk);
      chk("R4 one pop per strobe", head, h0 + 1);
      chk("R5 dreq low after word", int'(dreq), 0);
      dack = 1'b0; cyc(4); @(negedge clk);
      chk("R5 dreq back if words remain", int'(dreq), (i < 2) ? 1 : 0);
    end
    chk("R8 done after single packet", done_cnt, 1);
    chk("R7 busy offer not taken", int'(pkt_ready), 1);
    chk("R7 busy offer not taken dreq", int'(dreq), 0);

    // Burst packet of 4, mode flipped after handshake.
    send_pkt(4, 1'b1, 2);
    burst_mode = 1'b0;
    wait_dreq();
    dack = 1'b1; cyc(1);
    for (int i = 0; i < 4; i++) begin
      strobe(); @(negedge clk);
      chk("R6 burst dreq across words", int'(dreq), (i < 3) ? 1 : 0);
      if (i == 0) chk("R10 mode change ignored", int'(dreq), 1);
    end
    dack = 1'b0; cyc(4);
    chk("R8 done after burst", done_cnt, 2);

    // Zero-length packet.
    send_pkt(0, 1'b0, 3);
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      chk("R8 zero length no dreq", int'(dreq), 0);
    end
    chk("R8 zero length done", done_cnt, 3);

    // Burst of 2 with an aborted cycle.
    send_pkt(2, 1'b1, 4);
    wait_dreq();
    dack = 1'b1; cyc(1);
    h0 = head;
    rd_n = 1'b0; cyc(2); @(negedge clk);
    chk("R2 driving in strobe", int'(dbus_oe), 1);
    cyc(1); dack = 1'b0; @(negedge clk);
    chk("R3 immediate release", int'(dbus_oe), 0);
    cyc(4); rd_n = 1'b1; cyc(5); @(negedge clk);
    chk("R3 aborted cycle no pop", head, h0);
    dack = 1'b1; cyc(1);
    strobe(); strobe(); @(negedge clk);
    chk("R4 two pops", head, h0 + 2);
    chk("R6 dreq low after last", int'(dreq), 0);
    dack = 1'b0; cyc(4);
    chk("R8 done count", done_cnt, 4);
    chk("R2 scoreboard drained", exp_q.size(), 0);

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule